// File: doc/BRIEF.md
# Security-Banked Private Interrupt Register File

This block keeps the configuration and live state of the 32 private interrupts owned by one processor. It is reached over a simple request/response bus. Each request carries an offset, a size (byte, word or doubleword), write data and a secure/non-secure attribute. Every request receives exactly one response, one cycle later. The block never signals a bus error.

When the global security-disable input is low, non-secure requests are restricted. The group register acts as a per-interrupt permission mask. Interrupts whose group bit is 0 cannot be read or written by non-secure requests. Permitted priorities are shown to non-secure software in a rescaled form.

The enable, pending, active, priority and edge-trigger state is driven continuously to the pending-selection logic that sits next to the block.

Top module: `prf_regfile`

## Requirements
- R1: Word offsets are: 0x00 wake, 0x08/0x0C type (low/high), 0x10/0x14 table A, 0x18/0x1C table B, 0x20 group, 0x24 group modifier, 0x28 non-secure access control, 0x30/0x34 enable set/clear, 0x38/0x3C pending set/clear, 0x40/0x44 active set/clear, 0x48/0x4C trigger configuration 0/1, and 0x60..0x7F priorities. Size codes are 0 = byte, 2 = word and 3 = doubleword; code 1 is unsupported. Only the priority area accepts byte accesses. Only offsets 0x08, 0x10 and 0x18 accept doubleword accesses. A misaligned access, an unsupported size or an unmapped offset reads zero and changes nothing. `rsp_valid` follows `req_valid` by one cycle, and read data is right-justified in `rsp_rdata`. Every response to a write carries zero data.
- R2: Define "restricted" as `sec_disable`=0 together with a non-secure request. For restricted requests, the enable, pending, active and trigger-configuration registers read bit i as 0 and ignore writes to bit i whenever group bit i is 0.
- R3: A write to a set alias ORs the permitted write bits into the target register. A write to a clear alias clears the permitted write bits. The set alias and the clear alias read back the same permitted value.
- R4: The group register reads zero and ignores writes for restricted requests. All other requests can read and write it.
- R5: For a restricted request, a priority whose group bit is 1 reads as (p<<1)&0xFF, and a write to it stores 0x80|(v>>1). A priority whose group bit is 0 reads zero and ignores writes. Unrestricted requests read and write the raw 8-bit value.
- R6: A word access at priority offset 0x60+4k covers interrupts 4k..4k+3. Bits [7:0] belong to interrupt 4k. A byte access at 0x60+n covers interrupt n.
- R7: Interrupts 0..15 are always edge-triggered. Configuration word 0 ignores writes. A configuration word read places interrupt (16h+j)'s edge bit at bit 2j+1 and returns 0 in the even bits. A write to word 1 takes edge bits for interrupts 16..31 from the odd bits of the write data.
- R8: Pending reads, and `pending_vec`, equal the latched pending bits OR (not edge-triggered AND `irq_level`).
- R9: The group-modifier and access-control registers are readable and writable only by secure requests while `sec_disable` is 0. In every other case they read zero and ignore writes.
- R10: In the wake register, only bit 0 (sleep request) is writable. Bit 1 (asleep) always equals bit 0.
- R11: Tables A and B are 64-bit. They can be written and read either as word halves (low half at +0, high half at +4) or as a single doubleword. The type register returns `TYPE_VALUE` and ignores writes.
- R12: After reset, all state is zero except edge bits 0..15, which are 1. A write becomes visible on the state outputs in the cycle after its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_disable | input | 1 | Global security-disable flag |
| irq_level | input | 32 | Current input level of each private interrupt |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure request |
| req_size | input | 2 | Access size code |
| req_addr | input | 8 | Byte offset within the block |
| req_wdata | input | 64 | Write data, right-justified |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data, right-justified |
| enable_vec | output | 32 | Enable bits |
| pending_vec | output | 32 | Effective pending bits |
| active_vec | output | 32 | Active bits |
| edge_vec | output | 32 | Edge-trigger bits |
| prio_flat | output | 256 | Priorities; interrupt i at bits [8i+7:8i] |

## Verification
A request is presented on a falling edge and captured on the next rising edge. Its read data and `rsp_valid` are sampled on the falling edge that follows, because they pass through one register. The effect of a write on `enable_vec`, `active_vec`, `edge_vec` and `prio_flat` is sampled on that same falling edge. `pending_vec` also depends combinationally on `irq_level`, so it is checked shortly after the level changes, with no clock edge in between. Each bus task waits exactly one falling edge after issuing its request, so every comparison lands in the cycle where the result is due.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int NIRQ    = 32;
  localparam int PRIO_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 64;
  localparam int REG_W   = 32;
  localparam int IDX_W   = $clog2(NIRQ);
  localparam int HALF    = NIRQ / 2;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  localparam logic [ADDR_W-1:0] OFS_WAKE    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TYPE    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TYPE_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_TA      = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_TA_HI   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_TB      = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TB_HI   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_GROUP   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_GMOD    = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_NSAC    = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_EN_S    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_EN_C    = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_PD_S    = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_PD_C    = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_AC_S    = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_AC_C    = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_CFG0    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_CFG1    = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_PRIO    = 8'h60;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_WAKE, SEL_TYPE_LO, SEL_TYPE_HI, SEL_TYPE64,
    SEL_TA_LO, SEL_TA_HI, SEL_TA64, SEL_TB_LO, SEL_TB_HI, SEL_TB64,
    SEL_GROUP, SEL_GMOD, SEL_NSAC, SEL_EN_S, SEL_EN_C, SEL_PD_S,
    SEL_PD_C, SEL_AC_S, SEL_AC_C, SEL_CFG0, SEL_CFG1, SEL_PRIO_B,
    SEL_PRIO_W
  } reg_sel_e;

  // Restricted-view priority as returned to a non-secure reader
  function automatic logic [PRIO_W-1:0] prio_ns_view(input logic [PRIO_W-1:0] p);
    return {p[PRIO_W-2:0], 1'b0};
  endfunction

  // Value stored when a non-secure writer supplies v
  function automatic logic [PRIO_W-1:0] prio_ns_store(input logic [PRIO_W-1:0] v);
    return {1'b1, v[PRIO_W-1:1]};
  endfunction

  // One edge bit per interrupt -> odd bit of each 2-bit config field
  function automatic logic [REG_W-1:0] cfg_spread(input logic [HALF-1:0] h);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < HALF; i++) w[2*i+1] = h[i];
    return w;
  endfunction

  function automatic logic [HALF-1:0] cfg_squeeze(input logic [REG_W-1:0] w);
    logic [HALF-1:0] h;
    for (int i = 0; i < HALF; i++) h[i] = w[2*i+1];
    return h;
  endfunction
endpackage

// File: rtl/prf_decode.sv
module prf_decode
  import prf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output reg_sel_e          sel
);
  localparam int PRIO_LSB = IDX_W;

  logic aligned;
  logic in_prio;

  assign in_prio = (addr[ADDR_W-1:PRIO_LSB] == OFS_PRIO[ADDR_W-1:PRIO_LSB]);

  always_comb begin
    case (size)
      SZ_BYTE:  aligned = 1'b1;
      SZ_WORD:  aligned = (addr[1:0] == 2'b00);
      SZ_DWORD: aligned = (addr[2:0] == 3'b000);
      default:  aligned = 1'b0;
    endcase
  end

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (size == SZ_BYTE) begin
        if (in_prio) sel = SEL_PRIO_B;
      end else if (size == SZ_WORD) begin
        if (in_prio) sel = SEL_PRIO_W;
        else begin
          case (addr)
            OFS_WAKE:    sel = SEL_WAKE;
            OFS_TYPE:    sel = SEL_TYPE_LO;
            OFS_TYPE_HI: sel = SEL_TYPE_HI;
            OFS_TA:      sel = SEL_TA_LO;
            OFS_TA_HI:   sel = SEL_TA_HI;
            OFS_TB:      sel = SEL_TB_LO;
            OFS_TB_HI:   sel = SEL_TB_HI;
            OFS_GROUP:   sel = SEL_GROUP;
            OFS_GMOD:    sel = SEL_GMOD;
            OFS_NSAC:    sel = SEL_NSAC;
            OFS_EN_S:    sel = SEL_EN_S;
            OFS_EN_C:    sel = SEL_EN_C;
            OFS_PD_S:    sel = SEL_PD_S;
            OFS_PD_C:    sel = SEL_PD_C;
            OFS_AC_S:    sel = SEL_AC_S;
            OFS_AC_C:    sel = SEL_AC_C;
            OFS_CFG0:    sel = SEL_CFG0;
            OFS_CFG1:    sel = SEL_CFG1;
            default:     sel = SEL_NONE;
          endcase
        end
      end else if (size == SZ_DWORD) begin
        case (addr)
          OFS_TYPE: sel = SEL_TYPE64;
          OFS_TA:   sel = SEL_TA64;
          OFS_TB:   sel = SEL_TB64;
          default:  sel = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/prf_bitmap_bank.sv
module prf_bitmap_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] eff;
  assign eff = wdata & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (set_we) q <= q | eff;
    else if (clr_we) q <= q & ~eff;
  end

  AST_BANK_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || clr_we) |=> (((q ^ $past(q)) & ~$past(mask)) == '0)); // R2
  AST_BANK_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> (($past(q) & ~q) == '0)); // R3
  AST_BANK_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((q & ~$past(q)) == '0)); // R3
endmodule

// File: rtl/prf_prio_bank.sv
module prf_prio_bank
  import prf_pkg::*;
#(
  parameter int N     = NIRQ,
  parameter int LANES = 4,
  parameter int IW    = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_we,
  input  logic                  word_we,
  input  logic [IW-1:0]         idx,
  input  logic [PRIO_W*LANES-1:0] wdata,
  input  logic                  ns_restrict,
  input  logic [N-1:0]          group,
  output logic [PRIO_W*N-1:0]   prio_flat,
  output logic [PRIO_W-1:0]     rd_byte,
  output logic [PRIO_W*LANES-1:0] rd_word
);
  localparam int LSB = $clog2(LANES);
  localparam int GW  = IW - LSB;

  logic [PRIO_W-1:0] view [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam int L = i % LANES;
    logic              hit;
    logic              permit;
    logic [PRIO_W-1:0] wval;
    logic [PRIO_W-1:0] lane_q;

    assign permit = !ns_restrict || group[i];
    assign hit    = (byte_we && (idx == IW'(i))) ||
                    (word_we && (idx[IW-1:LSB] == GW'(i / LANES)));
    assign wval   = byte_we ? wdata[PRIO_W-1:0] : wdata[PRIO_W*L +: PRIO_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lane_q <= '0;
      else if (hit && permit) lane_q <= ns_restrict ? prio_ns_store(wval) : wval;
    end

    assign view[i] = !ns_restrict ? lane_q :
                     (group[i] ? prio_ns_view(lane_q) : '0);
    assign prio_flat[PRIO_W*i +: PRIO_W] = lane_q;

    AST_PRIO_NS_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && permit && ns_restrict) |=> lane_q[PRIO_W-1]); // R5
    AST_PRIO_NS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !permit) |=> $stable(lane_q)); // R5
  end

  assign rd_byte = view[idx];

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rd_word[PRIO_W*k +: PRIO_W] = view[{idx[IW-1:LSB], LSB'(k)}];
  end

  AST_PRIO_ONE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_we && word_we)); // R6
endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
  import prf_pkg::*;
#(
  parameter logic [63:0] TYPE_VALUE = 64'h0000_0100_0000_0021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_disable,
  input  logic [31:0]       irq_level,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [1:0]        req_size,
  input  logic [7:0]        req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic [31:0]       enable_vec,
  output logic [31:0]       pending_vec,
  output logic [31:0]       active_vec,
  output logic [31:0]       edge_vec,
  output logic [255:0]      prio_flat
);
  localparam int NBANK = 3;
  localparam logic [HALF-1:0] FIXED_EDGE = '1;

  reg_sel_e sel;
  logic wr, rd, bad;
  logic ns_restrict, sec_only_ok;
  logic [NIRQ-1:0] grp_mask;
  logic [REG_W-1:0] w32;

  logic [NIRQ-1:0] group_q, gmod_q, nsac_q, edge_q;
  logic            wake_sleep_q, wake_asleep_q;
  logic [63:0]     tbl_a_q, tbl_b_q;
  logic [NIRQ-1:0] pend_view;
  logic [63:0]     rdata_c;

  logic [NBANK-1:0] bank_set, bank_clr;
  logic [NIRQ-1:0]  bank_q [NBANK];
  logic [PRIO_W-1:0]   prio_rd_byte;
  logic [4*PRIO_W-1:0] prio_rd_word;
  logic [HALF-1:0]     cfg_new;
  logic [HALF-1:0]     cfg_mask;

  prf_decode u_decode (.addr(req_addr), .size(req_size), .sel(sel));

  assign wr          = req_valid && req_write;
  assign rd          = req_valid && !req_write;
  assign bad         = (sel == SEL_NONE);
  assign ns_restrict = !req_secure && !sec_disable;
  assign sec_only_ok = req_secure && !sec_disable;
  assign grp_mask    = ns_restrict ? group_q : '1;
  assign w32         = req_wdata[REG_W-1:0];

  // Enable, latched pending, active: set/clear bitmap banks
  assign bank_set = {wr && sel == SEL_AC_S, wr && sel == SEL_PD_S, wr && sel == SEL_EN_S};
  assign bank_clr = {wr && sel == SEL_AC_C, wr && sel == SEL_PD_C, wr && sel == SEL_EN_C};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    prf_bitmap_bank #(.W(NIRQ)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_we(bank_set[b]), .clr_we(bank_clr[b]),
      .wdata(w32), .mask(grp_mask), .q(bank_q[b]));
  end

  prf_prio_bank #(.N(NIRQ), .LANES(4)) u_prio (
    .clk(clk), .rst_n(rst_n),
    .byte_we(wr && sel == SEL_PRIO_B), .word_we(wr && sel == SEL_PRIO_W),
    .idx(req_addr[IDX_W-1:0]), .wdata(w32), .ns_restrict(ns_restrict),
    .group(group_q), .prio_flat(prio_flat), .rd_byte(prio_rd_byte),
    .rd_word(prio_rd_word));

  assign cfg_new  = cfg_squeeze(w32);
  assign cfg_mask = grp_mask[NIRQ-1:HALF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      group_q       <= '0;
      gmod_q        <= '0;
      nsac_q        <= '0;
      edge_q        <= {{HALF{1'b0}}, FIXED_EDGE};
      wake_sleep_q  <= 1'b0;
      wake_asleep_q <= 1'b0;
      tbl_a_q       <= '0;
      tbl_b_q       <= '0;
    end else if (wr) begin
      case (sel)
        SEL_GROUP: if (!ns_restrict) group_q <= w32;
        SEL_GMOD:  if (sec_only_ok) gmod_q <= w32;
        SEL_NSAC:  if (sec_only_ok) nsac_q <= w32;
        SEL_CFG1:  edge_q[NIRQ-1:HALF] <= (edge_q[NIRQ-1:HALF] & ~cfg_mask) | (cfg_new & cfg_mask);
        SEL_WAKE: begin
          wake_sleep_q  <= w32[0];
          wake_asleep_q <= w32[0];
        end
        SEL_TA_LO: tbl_a_q[31:0]  <= w32;
        SEL_TA_HI: tbl_a_q[63:32] <= w32;
        SEL_TA64:  tbl_a_q        <= req_wdata;
        SEL_TB_LO: tbl_b_q[31:0]  <= w32;
        SEL_TB_HI: tbl_b_q[63:32] <= w32;
        SEL_TB64:  tbl_b_q        <= req_wdata;
        default: ;
      endcase
    end
  end

  assign pend_view = bank_q[1] | (~edge_q & irq_level);

  always_comb begin
    case (sel)
      SEL_WAKE:    rdata_c = {62'b0, wake_asleep_q, wake_sleep_q};
      SEL_TYPE_LO: rdata_c = {32'b0, TYPE_VALUE[31:0]};
      SEL_TYPE_HI: rdata_c = {32'b0, TYPE_VALUE[63:32]};
      SEL_TYPE64:  rdata_c = TYPE_VALUE;
      SEL_TA_LO:   rdata_c = {32'b0, tbl_a_q[31:0]};
      SEL_TA_HI:   rdata_c = {32'b0, tbl_a_q[63:32]};
      SEL_TA64:    rdata_c = tbl_a_q;
      SEL_TB_LO:   rdata_c = {32'b0, tbl_b_q[31:0]};
      SEL_TB_HI:   rdata_c = {32'b0, tbl_b_q[63:32]};
      SEL_TB64:    rdata_c = tbl_b_q;
      SEL_GROUP:   rdata_c = {32'b0, ns_restrict ? '0 : group_q};
      SEL_GMOD:    rdata_c = {32'b0, sec_only_ok ? gmod_q : '0};
      SEL_NSAC:    rdata_c = {32'b0, sec_only_ok ? nsac_q : '0};
      SEL_EN_S, SEL_EN_C: rdata_c = {32'b0, bank_q[0] & grp_mask};
      SEL_PD_S, SEL_PD_C: rdata_c = {32'b0, pend_view & grp_mask};
      SEL_AC_S, SEL_AC_C: rdata_c = {32'b0, bank_q[2] & grp_mask};
      SEL_CFG0:    rdata_c = {32'b0, cfg_spread(edge_q[HALF-1:0] & grp_mask[HALF-1:0])};
      SEL_CFG1:    rdata_c = {32'b0, cfg_spread(edge_q[NIRQ-1:HALF] & grp_mask[NIRQ-1:HALF])};
      SEL_PRIO_B:  rdata_c = {56'b0, prio_rd_byte};
      SEL_PRIO_W:  rdata_c = {32'b0, prio_rd_word};
      default:     rdata_c = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd ? rdata_c : '0;
    end
  end

  assign enable_vec  = bank_q[0];
  assign pending_vec = pend_view;
  assign active_vec  = bank_q[2];
  assign edge_vec    = edge_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bad) |=> (rsp_rdata == '0)); // R1
  AST_BAD_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bad) |=> ($stable(tbl_a_q) && $stable(tbl_b_q) && $stable(edge_q) && $stable(group_q))); // R1
  AST_GROUP_NS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ns_restrict) |=> $stable(group_q)); // R4
  AST_EDGE_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> $stable(edge_q[HALF-1:0])); // R7
  AST_GMOD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sec_only_ok) |=> ($stable(gmod_q) && $stable(nsac_q))); // R9
  AST_WAKE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    wake_asleep_q == wake_sleep_q); // R10
endmodule

// File: tb/prf_regfile_tb.sv
module prf_regfile_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_disable = 1'b0;
  logic [31:0] irq_level = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [7:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid;
  logic [63:0] rsp_rdata;
  logic [31:0] enable_vec, pending_vec, active_vec, edge_vec;
  logic [255:0] prio_flat;

  int n_chk = 0;
  int n_bad = 0;
  localparam logic [63:0] TV = 64'h0000_0100_0000_0021;
  localparam logic S = 1'b1, NS = 1'b0;

  always #2 clk = ~clk;

  prf_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .irq_level(irq_level),
    .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .enable_vec(enable_vec),
    .pending_vec(pending_vec), .active_vec(active_vec), .edge_vec(edge_vec),
    .prio_flat(prio_flat));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic sec, input logic [1:0] sz,
                    input logic [7:0] a, input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_secure = sec;
    req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    r = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr32(input logic sec, input logic [7:0] a, input logic [31:0] d);
    logic [63:0] r;
    op(1'b1, sec, 2'd2, a, {32'b0, d}, r);
  endtask

  task automatic rd32(input logic sec, input logic [7:0] a, output logic [63:0] r);
    op(1'b0, sec, 2'd2, a, '0, r);
  endtask

  task automatic t_reset;
    check("R12 reset enable", enable_vec, 0);
    check("R12 reset active", active_vec, 0);
    check("R12 reset edge", edge_vec, 64'h0000FFFF);
    check("R12 reset prio", {63'b0, |prio_flat}, 0);
    check("R1 reset rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_group;
    logic [63:0] r;
    wr32(NS, 8'h20, 32'hFFFF0000);
    rd32(S, 8'h20, r);  check("R4 ns write ignored", r, 0);
    wr32(S, 8'h20, 32'h0F0F00FF);
    rd32(NS, 8'h20, r); check("R4 ns read zero", r, 0);
    rd32(S, 8'h20, r);  check("R4 secure read", r, 64'h0F0F00FF);
    sec_disable = 1'b1;
    wr32(NS, 8'h20, 32'h0000FFFF);
    rd32(NS, 8'h20, r); check("R4 ns access with security off", r, 64'h0000FFFF);
    sec_disable = 1'b0;
  endtask

  task automatic t_bitmaps;
    logic [63:0] r;
    wr32(NS, 8'h30, 32'hFFFFFFFF);
    check("R2 ns enable set masked", enable_vec, 64'h0000FFFF);
    rd32(NS, 8'h30, r); check("R3 set alias read", r, 64'h0000FFFF);
    wr32(S, 8'h30, 32'hFFFF0000);
    check("R3 secure set ORs", enable_vec, 64'hFFFFFFFF);
    wr32(NS, 8'h34, 32'hFFFFFFFF);
    check("R2 ns clear masked", enable_vec, 64'hFFFF0000);
    rd32(NS, 8'h34, r); check("R2 ns clear alias read", r, 0);
    rd32(S, 8'h34, r);  check("R3 clear alias read", r, 64'hFFFF0000);
    wr32(S, 8'h40, 32'h00010001);
    check("R3 active set", active_vec, 64'h00010001);
    wr32(NS, 8'h44, 32'hFFFFFFFF);
    check("R2 ns active clear", active_vec, 64'h00010000);
  endtask

  task automatic t_pending;
    logic [63:0] r;
    irq_level = 32'h00F00000;
    #1 check("R8 level pending", pending_vec, 64'h00F00000);
    rd32(S, 8'h38, r);  check("R8 pending read", r, 64'h00F00000);
    rd32(NS, 8'h3C, r); check("R2 ns pending read masked", r, 0);
    wr32(S, 8'h4C, 32'h00000200);
    check("R7 cfg1 write irq20", edge_vec, 64'h0010FFFF);
    check("R8 edge hides level", pending_vec, 64'h00E00000);
    wr32(S, 8'h38, 32'h00000001);
    check("R8 latched OR level", pending_vec, 64'h00E00001);
    wr32(NS, 8'h3C, 32'h00000001);
    check("R3 ns pending clear permitted", pending_vec, 64'h00E00000);
    irq_level = '0;
    #1 check("R8 level drop", pending_vec, 0);
  endtask

  task automatic t_cfg;
    logic [63:0] r;
    rd32(S, 8'h48, r);  check("R7 cfg0 read", r, 64'hAAAAAAAA);
    rd32(S, 8'h4C, r);  check("R7 cfg1 read spread", r, 64'h00000200);
    wr32(S, 8'h4C, 32'hD5555555);
    check("R7 odd bits only", edge_vec, 64'h8000FFFF);
    rd32(S, 8'h4C, r);  check("R7 cfg1 readback", r, 64'h80000000);
    wr32(NS, 8'h4C, 32'hAAAAAAAA);
    check("R2 ns cfg write masked", edge_vec, 64'h8000FFFF);
    rd32(NS, 8'h4C, r); check("R2 ns cfg1 read masked", r, 0);
    wr32(S, 8'h48, 32'h0);
    check("R7 cfg0 ignores writes", edge_vec, 64'h8000FFFF);
  endtask

  task automatic t_prio;
    logic [63:0] r;
    wr32(S, 8'h60, 32'h44332211);
    check("R6 word write lane0", prio_flat[7:0], 64'h11);
    check("R6 word write lane3", prio_flat[31:24], 64'h44);
    op(1'b0, S, 2'd0, 8'h62, '0, r); check("R6 byte read irq2", r, 64'h33);
    op(1'b0, NS, 2'd0, 8'h61, '0, r); check("R5 ns byte view", r, 64'h44);
    op(1'b1, NS, 2'd0, 8'h63, 64'h10, r);
    check("R5 ns store", prio_flat[31:24], 64'h88);
    wr32(NS, 8'h70, 32'hFFFFFFFF);
    check("R5 ns write to secure ignored", prio_flat[159:128], 0);
    wr32(S, 8'h70, 32'h90807060);
    check("R6 secure word at 16", prio_flat[159:128], 64'h90807060);
    rd32(NS, 8'h70, r); check("R5 ns read secure zero", r, 0);
    rd32(NS, 8'h60, r); check("R5 ns word view", r, 64'h10664422);
  endtask

  task automatic t_ctrl;
    logic [63:0] r;
    wr32(S, 8'h24, 32'h0000ABCD);
    rd32(S, 8'h24, r);  check("R9 secure gmod", r, 64'hABCD);
    wr32(NS, 8'h24, 32'h0);
    rd32(S, 8'h24, r);  check("R9 ns write ignored", r, 64'hABCD);
    rd32(NS, 8'h24, r); check("R9 ns read zero", r, 0);
    sec_disable = 1'b1;
    rd32(S, 8'h24, r);  check("R9 read zero security off", r, 0);
    wr32(S, 8'h28, 32'h5);
    sec_disable = 1'b0;
    rd32(S, 8'h28, r);  check("R9 access control write ignored", r, 0);
    wr32(S, 8'h28, 32'h5);
    rd32(S, 8'h28, r);  check("R9 access control secure", r, 64'h5);
  endtask

  task automatic t_wake;
    logic [63:0] r;
    wr32(NS, 8'h00, 32'h1);
    rd32(NS, 8'h00, r); check("R10 sleep sets asleep", r, 64'h3);
    wr32(S, 8'h00, 32'hFFFFFFFE);
    rd32(S, 8'h00, r);  check("R10 only bit0 writable", r, 0);
  endtask

  task automatic t_tables;
    logic [63:0] r;
    op(1'b1, S, 2'd3, 8'h10, 64'h1122334455667788, r);
    op(1'b0, S, 2'd3, 8'h10, '0, r); check("R11 dword table A", r, 64'h1122334455667788);
    rd32(S, 8'h14, r); check("R11 high half", r, 64'h11223344);
    wr32(NS, 8'h10, 32'hDEADBEEF);
    op(1'b0, S, 2'd3, 8'h10, '0, r); check("R11 low half write", r, 64'h11223344DEADBEEF);
    wr32(S, 8'h1C, 32'hCAFE0001);
    op(1'b0, S, 2'd3, 8'h18, '0, r); check("R11 table B high", r, 64'hCAFE000100000000);
    op(1'b1, S, 2'd3, 8'h08, 64'hFFFFFFFFFFFFFFFF, r);
    op(1'b0, S, 2'd3, 8'h08, '0, r); check("R11 type read only", r, TV);
    rd32(S, 8'h0C, r); check("R11 type high word", r, {32'b0, TV[63:32]});
  endtask

  task automatic t_reserved;
    logic [63:0] r;
    rd32(S, 8'h50, r); check("R1 unmapped read", r, 0);
    check("R1 rsp_valid", rsp_valid, 1);
    @(negedge clk); check("R1 rsp idle", rsp_valid, 0);
    rd32(S, 8'h22, r); check("R1 misaligned read", r, 0);
    op(1'b1, S, 2'd2, 8'h31, 64'hFFFFFFFF, r);
    check("R1 misaligned write ignored", enable_vec, 64'hFFFF0000);
    op(1'b1, S, 2'd1, 8'h30, 64'hFFFFFFFF, r);
    check("R1 halfword write ignored", enable_vec, 64'hFFFF0000);
    op(1'b0, S, 2'd0, 8'h20, '0, r); check("R1 byte read non-prio", r, 0);
    op(1'b0, S, 2'd3, 8'h20, '0, r); check("R1 dword read unmapped", r, 0);
    op(1'b0, S, 2'd2, 8'h61, '0, r); check("R1 misaligned prio word", r, 0);
    op(1'b1, S, 2'd3, 8'h10, 64'h1, r);
    check("R1 write response data zero", r, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_group();
    t_bitmaps();
    t_pending();
    t_cfg();
    t_prio();
    t_ctrl();
    t_wake();
    t_tables();
    t_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule